// File: doc/BRIEF.md
# Half-Bit Tick Generator with Window and Gap Timers

This block produces the half-bit timing enable used by a USB Power Delivery baseband PHY and the two delay timers that run on it. A fast kernel clock first passes through a power-of-two prescaler. A programmable half-bit divider follows it and emits a one-cycle enable at the half-bit rate. A transition-window timer and an inter-frame-gap timer count that enable. Each timer has its own start strobe and its own one-cycle done pulse.

All settings come from one 32-bit configuration word. Every divide and count field holds the wanted value minus one. The word can be replaced only while the block is off. While the block is on, a write can change the enable bit and nothing else. Turning the block off aborts both timers and puts every counter back to its reset value. Typical use: with a 16 MHz kernel clock, prescale 1 and a half-bit divide of 26 give a tick of about 615 kHz (1.625 µs). Eight half-bit periods then give a 13 µs transition window, and seventeen give an inter-frame gap of about 27.6 µs.

Top module: `pd_hbit_timer`

## Requirements
- R1: The configuration fields sit at fixed positions. The half-bit divide-minus-one is in bits [5:0], the gap count-minus-one in [10:6], the window count-minus-one in [15:11], the prescale select in [19:17] and the enable in bit 31. All other bits have no effect.
- R2: While enabled, `hbitTick` repeats every P = (divide field + 1) × 2^min(select, 4) kernel cycles. The first tick comes in the P-th cycle after the cycle in which enable takes effect.
- R3: When P is at least 2, each `hbitTick` is exactly one kernel cycle wide.
- R4: A prescale select above 4 divides by 16, exactly as a select of 4 does.
- R5: After a window start, `winDone` pulses for one cycle on the (window field + 1)-th tick. Ticks in the start cycle itself are not counted.
- R6: After a gap start, `gapDone` pulses for one cycle on the (gap field + 1)-th tick, counted in the same way.
- R7: A start given while its timer is running restarts the count from zero.
- R8: While disabled, no tick and no done pulse are produced, and start strobes are ignored.
- R9: A configuration write made while enabled updates only the enable bit. The tick period is unchanged by the other fields of that write.
- R10: Clearing enable aborts any running timer. After re-enabling, no done pulse appears until a new start is given.
- R11: After reset the block is disabled and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgWord | input | 32 | Packed configuration word |
| winStart | input | 1 | Start or restart the transition-window timer |
| gapStart | input | 1 | Start or restart the inter-frame-gap timer |
| hbitTick | output | 1 | One-cycle half-bit enable |
| winDone | output | 1 | Window timer expiry pulse |
| gapDone | output | 1 | Gap timer expiry pulse |

## Verification
Several properties are checked on every cycle. The configuration fields stay frozen while the block is enabled, and the divider counters sit at zero while it is off. A tick is never followed by another tick unless the period is one cycle, and a done pulse without a coincident start is never repeated in the next cycle. A timer's count never exceeds its programmed length, and a timer is idle in the cycle after enable falls. The exact tick period, the prescale clamp, the count of ticks between a start and its done, the restart behaviour, and the absence of any done pulse after an abort can only be shown by the bench's scenarios. The bench compares these against its cycle-level model.

// File: rtl/hbt_pkg.sv
package hbt_pkg;
  // Configuration word layout
  localparam int HDIV_LSB = 0;
  localparam int HDIV_W   = 6;
  localparam int GAP_LSB  = 6;
  localparam int WIN_LSB  = 11;
  localparam int CNT_W    = 5;
  localparam int PSEL_LSB = 17;
  localparam int PSEL_W   = 3;
  localparam int EN_BIT   = 31;
  localparam int CFG_W    = 32;
  localparam int NUM_TMR  = 2;
  localparam int TMR_WIN  = 0;
  localparam int TMR_GAP  = 1;

  typedef struct packed {
    logic run;
    logic tick;
    logic winStart;
    logic gapStart;
  } hbt_strobe_t;
endpackage

// File: rtl/hbt_timer.sv
module hbt_timer #(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             run,
  input  logic             tick,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             done
);
  logic             busy;
  logic [LEN_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN || !run) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= '0;
    end else if (busy && tick) begin
      if (cnt == len) busy <= 1'b0;
      else            cnt  <= cnt + 1'b1;
    end
  end

  assign done = run && busy && tick && (cnt == len);

  // R5 and R6: a done pulse not coincident with a restart lasts one cycle
  assert_done_single_R5_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> !done);
  // R7: a running count never passes its programmed length
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (cnt <= len));
  // R10: dropping the run strobe leaves the timer idle one cycle later
  assert_abort_R10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(run) |=> !busy);
endmodule

// File: rtl/hbt_ctrl.sv
module hbt_ctrl
  import hbt_pkg::*;
#(
  parameter int PS_MAX_LOG = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             winStartIn,
  input  logic             gapStartIn,
  output hbt_strobe_t      strobe,
  output logic [CNT_W-1:0] winLen,
  output logic [CNT_W-1:0] gapLen
);
  localparam int PS_W = PS_MAX_LOG;

  logic              enQ;
  logic [HDIV_W-1:0] hdivQ;
  logic [CNT_W-1:0]  gapQ;
  logic [CNT_W-1:0]  winQ;
  logic [PSEL_W-1:0] pselQ;
  logic [PSEL_W-1:0] psLog;
  logic [PS_W-1:0]   psMask;
  logic [PS_W-1:0]   psCnt;
  logic [HDIV_W-1:0] hbCnt;
  logic              psTick;
  logic              tick;
  logic              unusedCfg;

  assign unusedCfg = ^{cfgWord[EN_BIT-1:PSEL_LSB+PSEL_W], cfgWord[PSEL_LSB-1:WIN_LSB+CNT_W]};

  // Configuration register: whole word only while disabled
  always_ff @(posedge clk) begin
    if (!rstN) begin
      enQ   <= 1'b0;
      hdivQ <= '0;
      gapQ  <= '0;
      winQ  <= '0;
      pselQ <= '0;
    end else if (cfgWe) begin
      enQ <= cfgWord[EN_BIT];
      if (!enQ) begin
        hdivQ <= cfgWord[HDIV_LSB +: HDIV_W];
        gapQ  <= cfgWord[GAP_LSB  +: CNT_W];
        winQ  <= cfgWord[WIN_LSB  +: CNT_W];
        pselQ <= cfgWord[PSEL_LSB +: PSEL_W];
      end
    end
  end

  assign psLog  = (pselQ > PSEL_W'(PS_MAX_LOG)) ? PSEL_W'(PS_MAX_LOG) : pselQ;
  assign psMask = PS_W'((32'd1 << psLog) - 32'd1);
  assign psTick = (psCnt == psMask);
  assign tick   = enQ && psTick && (hbCnt == hdivQ);

  // Prescaler and half-bit divider
  always_ff @(posedge clk) begin
    if (!rstN || !enQ) begin
      psCnt <= '0;
      hbCnt <= '0;
    end else begin
      psCnt <= psTick ? '0 : psCnt + 1'b1;
      if (psTick) hbCnt <= (hbCnt == hdivQ) ? '0 : hbCnt + 1'b1;
    end
  end

  assign strobe.run      = enQ;
  assign strobe.tick     = tick;
  assign strobe.winStart = enQ && winStartIn;
  assign strobe.gapStart = enQ && gapStartIn;
  assign winLen          = winQ;
  assign gapLen          = gapQ;

  // R9: fields are frozen while the block stays enabled
  assert_cfg_frozen_R9: assert property (@(posedge clk) disable iff (!rstN)
    (enQ && $past(enQ)) |-> $stable({hdivQ, gapQ, winQ, pselQ}));
  // R3: a tick is one cycle wide unless the period is a single cycle
  assert_tick_width_R3: assert property (@(posedge clk) disable iff (!rstN)
    (tick && !(hdivQ == '0 && psLog == '0)) |=> !tick);
  // R8: dividers rest at zero while disabled
  assert_idle_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!enQ && $past(!enQ)) |-> (psCnt == '0 && hbCnt == '0));
endmodule

// File: rtl/hbt_datapath.sv
module hbt_datapath
  import hbt_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  hbt_strobe_t      strobe,
  input  logic [CNT_W-1:0] winLen,
  input  logic [CNT_W-1:0] gapLen,
  output logic             winDone,
  output logic             gapDone
);
  logic [NUM_TMR-1:0]            startVec;
  logic [NUM_TMR-1:0]            doneVec;
  logic [NUM_TMR-1:0][CNT_W-1:0] lenVec;

  assign startVec[TMR_WIN] = strobe.winStart;
  assign startVec[TMR_GAP] = strobe.gapStart;
  assign lenVec[TMR_WIN]   = winLen;
  assign lenVec[TMR_GAP]   = gapLen;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    hbt_timer #(.LEN_W(CNT_W)) u_tmr (
      .clk  (clk),
      .rstN (rstN),
      .run  (strobe.run),
      .tick (strobe.tick),
      .start(startVec[i]),
      .len  (lenVec[i]),
      .done (doneVec[i])
    );
  end

  assign winDone = doneVec[TMR_WIN];
  assign gapDone = doneVec[TMR_GAP];

  // R8: no expiry while the block is off
  assert_no_done_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.run |-> (doneVec == '0));
endmodule

// File: rtl/pd_hbit_timer.sv
module pd_hbit_timer
  import hbt_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWe,
  input  logic [31:0] cfgWord,
  input  logic        winStart,
  input  logic        gapStart,
  output logic        hbitTick,
  output logic        winDone,
  output logic        gapDone
);
  hbt_strobe_t      strobe;
  logic [CNT_W-1:0] winLen;
  logic [CNT_W-1:0] gapLen;

  hbt_ctrl #(.PS_MAX_LOG(4)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cfgWe     (cfgWe),
    .cfgWord   (cfgWord),
    .winStartIn(winStart),
    .gapStartIn(gapStart),
    .strobe    (strobe),
    .winLen    (winLen),
    .gapLen    (gapLen)
  );

  hbt_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .winLen (winLen),
    .gapLen (gapLen),
    .winDone(winDone),
    .gapDone(gapDone)
  );

  assign hbitTick = strobe.tick;
endmodule

// File: tb/pd_hbit_timer_tb.sv
module pd_hbit_timer_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWe = 1'b0;
  logic [31:0] cfgWord = '0;
  logic        winStart = 1'b0;
  logic        gapStart = 1'b0;
  logic        hbitTick, winDone, gapDone;

  int checks = 0;
  int failures = 0;

  pd_hbit_timer u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgWord(cfgWord),
    .winStart(winStart), .gapStart(gapStart),
    .hbitTick(hbitTick), .winDone(winDone), .gapDone(gapDone)
  );

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference model state
  bit mEn;
  int mHdiv, mGap, mWin, mPs, mAge;
  bit mWR, mGR;
  int mWT, mGT;
  int cyc, lastTick, period;
  int tickSeen, winSeen, gapSeen;
  bit wArm, gArm;
  int wCnt, gCnt;
  string wTag = "R5";

  always @(negedge clk) begin
    if (!rstN) begin
      mEn = 0; mHdiv = 0; mGap = 0; mWin = 0; mPs = 0; mAge = 0;
      mWR = 0; mGR = 0; mWT = 0; mGT = 0; wArm = 0; gArm = 0;
    end else begin
      int p;
      bit eTick, eWin, eGap;
      cyc++;
      p = (mHdiv + 1) * (1 << ((mPs > 4) ? 4 : mPs));
      eTick = mEn && (((mAge + 1) % p) == 0);
      eWin  = eTick && mWR && (mWT == mWin);
      eGap  = eTick && mGR && (mGT == mGap);
      chk(hbitTick === eTick, "R2", hbitTick, eTick);
      chk(winDone === eWin, "R5", winDone, eWin);
      chk(gapDone === eGap, "R6", gapDone, eGap);
      // observation statistics
      if (hbitTick) begin
        tickSeen++;
        if (lastTick >= 0) period = cyc - lastTick;
        lastTick = cyc;
      end
      if (mEn && winStart) begin wArm = 1; wCnt = 0; end
      else if (wArm && hbitTick) wCnt++;
      if (mEn && gapStart) begin gArm = 1; gCnt = 0; end
      else if (gArm && hbitTick) gCnt++;
      if (winDone) begin
        winSeen++;
        chk(wCnt == mWin + 1, wTag, wCnt, mWin + 1);
        wArm = 0;
      end
      if (gapDone) begin
        gapSeen++;
        chk(gCnt == mGap + 1, "R6", gCnt, mGap + 1);
        gArm = 0;
      end
      if (!mEn) begin wArm = 0; gArm = 0; end
      // model update for the coming edge
      if (mEn) begin
        mAge++;
        if (winStart) begin mWR = 1; mWT = 0; end
        else if (mWR && eTick) begin if (mWT == mWin) mWR = 0; else mWT++; end
        if (gapStart) begin mGR = 1; mGT = 0; end
        else if (mGR && eTick) begin if (mGT == mGap) mGR = 0; else mGT++; end
      end else begin
        mAge = 0; mWR = 0; mGR = 0;
      end
      if (cfgWe) begin
        if (!mEn) begin
          mHdiv = int'(cfgWord[5:0]);
          mGap  = int'(cfgWord[10:6]);
          mWin  = int'(cfgWord[15:11]);
          mPs   = int'(cfgWord[19:17]);
        end
        mEn = cfgWord[31];
      end
    end
  end

  function automatic logic [31:0] mk(input bit en, input int ps, input int win,
                                     input int gap, input int hdiv);
    logic [31:0] w = '0;
    w[31] = en; w[19:17] = 3'(ps); w[15:11] = 5'(win); w[10:6] = 5'(gap); w[5:0] = 6'(hdiv);
    return w;
  endfunction

  task automatic wr(input logic [31:0] w);
    @(posedge clk); #1;
    cfgWe = 1; cfgWord = w; lastTick = -1; period = -1;
    @(posedge clk); #1;
    cfgWe = 0;
  endtask

  task automatic pulseWin();
    @(posedge clk); #1 winStart = 1;
    @(posedge clk); #1 winStart = 0;
  endtask

  task automatic pulseGap();
    @(posedge clk); #1 gapStart = 1;
    @(posedge clk); #1 gapStart = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin
    #(4 * 200000);
    chk(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int t0, w0, g0;
    lastTick = -1; period = -1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    chk(hbitTick === 0, "R11", hbitTick, 0);
    chk(winDone === 0 && gapDone === 0, "R11", winDone | gapDone, 0);
    @(posedge clk); #1 rstN = 1;
    idle(3);
    chk(hbitTick === 0, "R11", hbitTick, 0);

    // R2: 16 MHz example, divide 26, window 8, gap 17
    wr(mk(1, 0, 7, 16, 25));
    idle(90);
    chk(period == 26, "R2", period, 26);
    pulseWin();
    idle(260);
    chk(winSeen == 1, "R5", winSeen, 1);
    pulseGap();
    idle(500);
    chk(gapSeen == 1, "R6", gapSeen, 1);

    // R7: restart window mid-count
    wTag = "R7";
    w0 = winSeen;
    pulseWin();
    idle(100);
    pulseWin();
    idle(150);
    chk(winSeen == w0, "R7", winSeen, w0);
    idle(100);
    chk(winSeen == w0 + 1, "R7", winSeen, w0 + 1);
    wTag = "R5";

    // R9: enabled write may only touch enable
    wr(mk(1, 0, 2, 2, 3));
    idle(90);
    chk(period == 26, "R9", period, 26);

    // R8: disabled - no ticks, starts ignored
    wr(mk(0, 0, 0, 0, 0));
    t0 = tickSeen; w0 = winSeen; g0 = gapSeen;
    pulseWin(); pulseGap();
    idle(200);
    chk(tickSeen == t0, "R8", tickSeen, t0);
    chk(winSeen == w0 && gapSeen == g0, "R8", winSeen + gapSeen, w0 + g0);

    // R2/R3: prescale 4, divide 4 -> period 16
    wr(mk(1, 2, 1, 3, 3));
    idle(60);
    chk(period == 16, "R3", period, 16);
    pulseWin(); pulseGap();
    idle(100);
    wr(mk(0, 0, 0, 0, 0));

    // R4: select 7 clamps to divide by 16
    wr(mk(1, 7, 0, 0, 1));
    idle(110);
    chk(period == 32, "R4", period, 32);
    wr(mk(0, 0, 0, 0, 0));
    wr(mk(1, 4, 0, 0, 1));
    idle(110);
    chk(period == 32, "R4", period, 32);
    wr(mk(0, 0, 0, 0, 0));

    // R1: undefined bits have no effect
    wr(mk(1, 1, 3, 2, 9) | 32'h7FF1_0000);
    idle(70);
    chk(period == 20, "R1", period, 20);
    pulseWin();
    idle(120);
    wr(mk(0, 0, 0, 0, 0));

    // Period of one cycle, zero lengths
    wr(mk(1, 0, 0, 0, 0));
    idle(5);
    pulseWin(); pulseGap();
    idle(10);
    chk(period == 1, "R2", period, 1);
    wr(mk(0, 0, 0, 0, 0));

    // R10: abort then re-enable without a start
    wr(mk(1, 0, 0, 16, 9));
    g0 = gapSeen;
    pulseGap();
    idle(50);
    wr(mk(0, 0, 0, 16, 9));
    wr(mk(1, 0, 0, 16, 9));
    idle(400);
    chk(gapSeen == g0, "R10", gapSeen, g0);
    pulseGap();
    idle(200);
    chk(gapSeen == g0 + 1, "R10", gapSeen, g0 + 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule